// File: doc/BRIEF.md
# Daisy-Chain Interrupt Unit with Cause-Coded Vector

This block is the interrupt section of a byte-wide DMA controller that sits on a prioritised interrupt daisy chain. Single-cycle request pulses arrive for four causes: ready, match, end-of-block, and match together with end-of-block. Each pulse is screened by its enable bit in the control byte and by the global enable. An accepted request makes the unit pending, which raises the interrupt request and stops priority from passing down the chain. The request also latches a vector, and that vector may carry the cause code in two of its bits.

The processor acknowledges the pending interrupt. The unit then returns the latched vector in the same cycle and moves to the under-service state. While under service it refuses new requests but still passes chain priority through, because only the pending state holds priority back. A return-from-interrupt releases the unit. A reset-and-disable command drops everything, and so does the synchronous reset.

The controller is an FSM with three states:
- `ST_IDLE`: nothing is pending.
- `ST_PEND`: the request is raised.
- `ST_SERV`: an acknowledged interrupt is being serviced.

Its transitions are:
- *accept*: IDLE→PEND on an accepted request.
- *refresh*: PEND→PEND when another request is accepted, which replaces the vector.
- *acknowledge*: PEND→SERV on `ack`.
- *release*: SERV→IDLE on `reti`.
- *abort*: any state→IDLE on the reset-and-disable command or on `rst`.

Top module: `dma_irq_chain`

## Requirements
- R1: `irq` is high exactly while the unit is pending. It rises in the cycle after an accepted request and falls in the cycle after the acknowledge.
- R2: `ieo` equals `iei` AND NOT pending, in every cycle. While under service, `ieo` follows `iei`.
- R3: A request is accepted only when the global enable is 1 and the unit is not under service. Any other request is dropped and leaves no trace.
- R4: Each cause has its own enable bit in `ctl`. Match uses bit 0, end-of-block uses bit 1 and ready uses bit 6. Match-with-end-of-block is enabled when bit 0 or bit 1 is set. A request for a disabled cause is dropped.
- R5: When `ctl` bit 5 is 1, the latched vector is `vec_base` with bits 2:1 replaced by the cause code (0 ready, 1 match, 2 end-of-block, 3 match with end-of-block). When bit 5 is 0, the latched vector is `vec_base` unchanged.
- R6: When several causes request in the same cycle, one is chosen in this order: match-with-end-of-block, then end-of-block, then match, then ready. A request accepted while the unit is already pending replaces the latched vector.
- R7: An `ack` while pending drives the latched vector on `vec_out` in that same cycle. The unit is then under service from the next cycle on. A request that arrives in the same cycle as this `ack` is dropped.
- R8: An `ack` with nothing pending drives `vec_out` = 0x00 and changes no state.
- R9: `reti` while under service returns the unit to idle, after which requests are accepted again. `reti` in any other state has no effect.
- R10: `stat_ip_n` (status bit 3, active low) goes to 0 in the cycle after a request is accepted. It returns to 1 only on the reset-and-disable command or on reset.
- R11: The `rst_dis` command clears the global enable, pending and under-service, and sets `stat_ip_n`. It overrides every other input in that cycle.
- R12: The synchronous active-high `rst` clears pending, under-service, the global enable and the latched vector, and sets `stat_ip_n` to 1.
- R13: A `gie_wr` pulse loads `gie_val` into the global enable, which takes effect for requests from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_wr | input | 1 | Load strobe for the global interrupt enable |
| gie_val | input | 1 | Value loaded into the global enable |
| rst_dis | input | 1 | Reset-and-disable command pulse |
| ctl | input | 8 | Interrupt-control byte (cause enables, vector modify bit) |
| vec_base | input | 8 | Programmed vector |
| req_rdy | input | 1 | Ready cause request pulse |
| req_mt | input | 1 | Match cause request pulse |
| req_eob | input | 1 | End-of-block cause request pulse |
| req_mteob | input | 1 | Match with end-of-block request pulse |
| iei | input | 1 | Priority in from the chain |
| ack | input | 1 | Interrupt acknowledge |
| reti | input | 1 | Return-from-interrupt seen on the bus |
| irq | output | 1 | Interrupt request |
| ieo | output | 1 | Priority out to the chain |
| vec_out | output | 8 | Vector returned during acknowledge, else 0 |
| stat_ip_n | output | 1 | Status bit 3, 0 when an interrupt became pending |

## Verification
The embedded properties check, on every cycle, the invariants that tie the outputs to the FSM:
- the request blocks `ieo` and pulls the status bit low;
- an acknowledge moves the unit to service;
- a release returns it to idle;
- the abort command clears everything;
- the cause grant is never more than one-hot.

Only the bench scenarios can show which value the vector carries for each cause code and modify setting. The same holds for priority among simultaneous causes, requests dropped for a cleared enable or while under service, and the refresh of the vector while pending.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SERV = 2'd2
    } irq_state_t;

    localparam int NUM_CAUSES  = 4;
    localparam int CODE_W      = 2;
    localparam int CTL_W       = 8;
    localparam int CTL_EN_MT   = 0;
    localparam int CTL_EN_EOB  = 1;
    localparam int CTL_VEC_MOD = 5;
    localparam int CTL_EN_RDY  = 6;

    localparam logic [CODE_W-1:0] CAUSE_RDY   = 2'd0;
    localparam logic [CODE_W-1:0] CAUSE_MT    = 2'd1;
    localparam logic [CODE_W-1:0] CAUSE_EOB   = 2'd2;
    localparam logic [CODE_W-1:0] CAUSE_MTEOB = 2'd3;
endpackage

// File: rtl/dma_irq_cause_sel.sv
module dma_irq_cause_sel
    import dma_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CAUSES-1:0] req,
    input  logic                  en_mt,
    input  logic                  en_eob,
    input  logic                  en_rdy,
    output logic                  hit,
    output logic [CODE_W-1:0]     code
);
    logic [NUM_CAUSES-1:0] cause_en;
    logic [NUM_CAUSES-1:0] live;
    logic [NUM_CAUSES-1:0] grant;

    always_comb begin
        cause_en              = '0;
        cause_en[CAUSE_RDY]   = en_rdy;
        cause_en[CAUSE_MT]    = en_mt;
        cause_en[CAUSE_EOB]   = en_eob;
        cause_en[CAUSE_MTEOB] = en_mt | en_eob;
    end

    assign live = req & cause_en;

    // Highest code wins: later loop iterations override earlier ones.
    always_comb begin
        grant = '0;
        code  = '0;
        for (int k = 0; k < NUM_CAUSES; k++) begin
            if (live[k]) begin
                grant    = '0;
                grant[k] = 1'b1;
                code     = CODE_W'(k);
            end
        end
    end

    assign hit = |grant;

    p_one_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant))
        else $error("p_one_cause_r6");
endmodule

// File: rtl/dma_irq_vec_mod.sv
module dma_irq_vec_mod #(
    parameter int VEC_W     = 8,
    parameter int FIELD_LSB = 1,
    parameter int FIELD_W   = 2
) (
    input  logic [VEC_W-1:0]   base,
    input  logic [FIELD_W-1:0] code,
    input  logic               modify,
    output logic [VEC_W-1:0]   vec
);
    localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        if (b >= FIELD_LSB && b <= FIELD_MSB) begin : g_field
            assign vec[b] = modify ? code[b-FIELD_LSB] : base[b];
        end else begin : g_keep
            assign vec[b] = base[b];
        end
    end
endmodule

// File: rtl/dma_irq_chain.sv
module dma_irq_chain
    import dma_irq_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int CODE_LSB  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gie_wr,
    input  logic             gie_val,
    input  logic             rst_dis,
    input  logic [CTL_W-1:0] ctl,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             req_rdy,
    input  logic             req_mt,
    input  logic             req_eob,
    input  logic             req_mteob,
    input  logic             iei,
    input  logic             ack,
    input  logic             reti,
    output logic             irq,
    output logic             ieo,
    output logic [VEC_W-1:0] vec_out,
    output logic             stat_ip_n
);
    irq_state_t        state, state_nx;
    logic              gie;
    logic [VEC_W-1:0]  vec_q;
    logic [VEC_W-1:0]  vec_new;
    logic              cause_hit;
    logic [CODE_W-1:0] cause_code;
    logic              accept;
    logic              take_ack;
    logic              ctl_unused;

    assign ctl_unused = ^{ctl[7], ctl[4:2]};

    dma_irq_cause_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .req    ({req_mteob, req_eob, req_mt, req_rdy}),
        .en_mt  (ctl[CTL_EN_MT]),
        .en_eob (ctl[CTL_EN_EOB]),
        .en_rdy (ctl[CTL_EN_RDY]),
        .hit    (cause_hit),
        .code   (cause_code)
    );

    dma_irq_vec_mod #(
        .VEC_W     (VEC_W),
        .FIELD_LSB (CODE_LSB),
        .FIELD_W   (CODE_W)
    ) u_vec (
        .base   (vec_base),
        .code   (cause_code),
        .modify (ctl[CTL_VEC_MOD]),
        .vec    (vec_new)
    );

    assign take_ack = (state == ST_PEND) && ack;
    assign accept   = cause_hit && gie && (state != ST_SERV) && !take_ack && !rst_dis;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nx = ST_PEND;
            ST_PEND: if (take_ack) state_nx = ST_SERV;
            ST_SERV: if (reti)     state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
        if (rst_dis) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            gie       <= 1'b0;
            vec_q     <= '0;
            stat_ip_n <= 1'b1;
        end else begin
            state <= state_nx;
            if (rst_dis) begin
                gie       <= 1'b0;
                stat_ip_n <= 1'b1;
            end else begin
                if (gie_wr) gie <= gie_val;
                if (accept) begin
                    vec_q     <= vec_new;
                    stat_ip_n <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        irq     = (state == ST_PEND);
        ieo     = iei && (state != ST_PEND);
        vec_out = take_ack ? vec_q : '0;
    end

    p_ieo_block_r2: assert property (@(posedge clk) disable iff (rst)
        irq |-> !ieo)
        else $error("p_ieo_block_r2");

    p_drop_in_service_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERV && !reti) |=> !irq)
        else $error("p_drop_in_service_r3");

    p_ack_to_service_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && !rst_dis) |=> (!irq && state == ST_SERV))
        else $error("p_ack_to_service_r7");

    p_idle_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERV && ack && !reti && !rst_dis) |=> (state == ST_SERV))
        else $error("p_idle_ack_r8");

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERV && reti && !rst_dis) |=> (state == ST_IDLE))
        else $error("p_release_r9");

    p_stat_low_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> !stat_ip_n)
        else $error("p_stat_low_r10");

    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        rst_dis |=> (!irq && stat_ip_n && state == ST_IDLE))
        else $error("p_abort_r11");
endmodule

// File: tb/dma_irq_chain_test.sv
module dma_irq_chain_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       gie_wr, gie_val, rst_dis;
    logic [7:0] ctl, vec_base;
    logic       req_rdy, req_mt, req_eob, req_mteob;
    logic       iei, ack, reti;
    logic       irq, ieo, stat_ip_n;
    logic [7:0] vec_out;

    always #5 clk = ~clk;

    dma_irq_chain uut (
        .clk(clk), .rst(rst), .gie_wr(gie_wr), .gie_val(gie_val), .rst_dis(rst_dis),
        .ctl(ctl), .vec_base(vec_base), .req_rdy(req_rdy), .req_mt(req_mt),
        .req_eob(req_eob), .req_mteob(req_mteob), .iei(iei), .ack(ack), .reti(reti),
        .irq(irq), .ieo(ieo), .vec_out(vec_out), .stat_ip_n(stat_ip_n)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // scoreboard: {irq, ieo, stat_ip_n, vec_out}
    logic [10:0] q_exp[$];
    string       q_tag[$];

    // bench model built from the requirements
    logic       m_pend, m_serv, m_gie, m_stat;
    logic [7:0] m_vec;

    // stimulus for the next cycle
    logic       s_gw, s_gv, s_rd, s_rdy, s_mt, s_eob, s_me, s_iei, s_ack, s_reti;
    logic [7:0] s_ctl, s_vb;

    task automatic clear_pulses();
        s_gw = 0; s_gv = 0; s_rd = 0; s_rdy = 0; s_mt = 0; s_eob = 0; s_me = 0;
        s_ack = 0; s_reti = 0;
    endtask

    task automatic step(input string tag);
        logic       hit;
        logic [1:0] code;
        logic [7:0] ev;
        @(negedge clk);
        #1;
        gie_wr = s_gw; gie_val = s_gv; rst_dis = s_rd; ctl = s_ctl; vec_base = s_vb;
        req_rdy = s_rdy; req_mt = s_mt; req_eob = s_eob; req_mteob = s_me;
        iei = s_iei; ack = s_ack; reti = s_reti;
        ev = (s_ack && m_pend) ? m_vec : 8'h00;
        q_exp.push_back({m_pend, s_iei & ~m_pend, m_stat, ev});
        q_tag.push_back(tag);
        hit = 1'b0; code = 2'd0;
        if (s_me && (s_ctl[0] || s_ctl[1]))  begin hit = 1; code = 2'd3; end
        else if (s_eob && s_ctl[1])          begin hit = 1; code = 2'd2; end
        else if (s_mt && s_ctl[0])           begin hit = 1; code = 2'd1; end
        else if (s_rdy && s_ctl[6])          begin hit = 1; code = 2'd0; end
        if (s_rd) begin
            m_gie = 0; m_pend = 0; m_serv = 0; m_stat = 1;
        end else begin
            if (s_ack && m_pend) begin
                m_pend = 0; m_serv = 1;
            end else if (s_reti && m_serv) begin
                m_serv = 0;
            end else if (hit && m_gie && !m_serv) begin
                m_pend = 1; m_stat = 0;
                m_vec  = s_ctl[5] ? {s_vb[7:3], code, s_vb[0]} : s_vb;
            end
            if (s_gw) m_gie = s_gv;
        end
        clear_pulses();
    endtask

    always begin
        @(negedge clk);
        #4;
        if (q_exp.size() > 0) begin
            logic [10:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_checks++;
            if ({irq, ieo, stat_ip_n, vec_out} !== e) begin
                n_fail++;
                $display("FAIL %s: got irq=%b ieo=%b stat=%b vec=%02h, expected irq=%b ieo=%b stat=%b vec=%02h",
                         t, irq, ieo, stat_ip_n, vec_out, e[10], e[9], e[8], e[7:0]);
            end
        end
    end

    task automatic lit_check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: model vector %02h expected %02h", tag, got, exp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; gie_wr = 0; gie_val = 0; rst_dis = 0; ctl = 0; vec_base = 0;
        req_rdy = 0; req_mt = 0; req_eob = 0; req_mteob = 0; iei = 1; ack = 0; reti = 0;
        clear_pulses(); s_ctl = 8'h00; s_vb = 8'h00; s_iei = 1;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        m_pend = 0; m_serv = 0; m_gie = 0; m_stat = 1; m_vec = 8'h00;

        step("R12 reset state");
        s_ctl = 8'h63; s_vb = 8'hA0;
        s_mt = 1; step("R3 request with enable clear");
        step("R3 R13 dropped request leaves irq low");
        s_gw = 1; s_gv = 1; step("R13 load enable");
        s_mt = 1; step("R1 R4 match accepted");
        lit_check("R5 match code vector", m_vec, 8'hA2);
        step("R1 R2 R10 pending visible");
        s_ack = 1; step("R7 ack returns vector");
        step("R7 now under service");
        s_eob = 1; step("R3 request under service");
        s_ack = 1; step("R8 ack with nothing pending");
        step("R2 R3 R8 state unchanged");
        s_iei = 0; step("R2 iei low in service");
        s_iei = 1; s_reti = 1; step("R9 reti");
        s_ctl = 8'h03; s_vb = 8'h5B; s_eob = 1; step("R5 eob without modify");
        lit_check("R5 unmodified vector", m_vec, 8'h5B);
        s_iei = 0; step("R2 pending iei low");
        s_iei = 1; s_ack = 1; step("R7 ack unmodified");
        s_reti = 1; step("R9 release");
        s_ctl = 8'h23; s_rdy = 1; step("R4 ready disabled");
        step("R4 ready dropped");
        s_ctl = 8'h60; s_vb = 8'hFF; s_rdy = 1; s_mt = 1; step("R4 R5 ready code with match disabled");
        lit_check("R5 ready code", m_vec, 8'hF9);
        s_ack = 1; step("R5 ack ready vector");
        s_reti = 1; s_ack = 0; step("R9 release again");
        s_ctl = 8'h63; s_vb = 8'h00; s_rdy = 1; s_mt = 1; s_eob = 1; s_me = 1;
        step("R6 all causes at once");
        lit_check("R6 top cause code", m_vec, 8'h06);
        s_eob = 1; s_vb = 8'h80; step("R6 refresh while pending");
        lit_check("R6 refreshed vector", m_vec, 8'h84);
        s_ack = 1; s_eob = 1; step("R7 ack drops same-cycle request");
        step("R7 service after ack");
        s_reti = 1; step("R9 release third");
        s_ctl = 8'h22; s_me = 1; step("R4 match-eob via eob enable");
        s_rd = 1; s_ack = 1; step("R11 abort overrides ack");
        step("R10 R11 status restored");
        s_ctl = 8'h63; s_mt = 1; step("R11 enable cleared drops request");
        step("R11 still idle");
        s_gw = 1; s_gv = 1; step("R13 reload enable");
        s_eob = 1; s_vb = 8'hC1; step("R4 eob accepted");
        s_ack = 1; step("R7 ack eob vector C5");
        lit_check("R5 eob code", m_vec, 8'hC5);
        @(negedge clk); #1 rst = 1;
        m_pend = 0; m_serv = 0; m_gie = 0; m_stat = 1; m_vec = 8'h00;
        @(negedge clk); #1 rst = 0;
        step("R12 reset from service");
        s_mt = 1; step("R12 enable cleared by reset");
        step("R12 request dropped after reset");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule